// File: doc/BRIEF.md
# Shift-and-Add Constant Multiplier with Signed-Digit Recoding

This block multiplies an unsigned `M`-bit operand by an `N`-bit constant `K` that is fixed at elaboration time. The result is the full unsigned `M+N`-bit product. It does not use a general multiplier. While the design elaborates, the constant is rewritten as signed digits from {-1, 0, +1}. One small adder is then generated for each non-zero digit after the first, so the amount of logic follows the constant: a sparse constant costs a few adders, and zero or a power of two costs none.

The recoding uses the usual non-adjacent form with one change. When the only part of the constant still to be recoded is the pair `11`, it becomes two +1 digits instead of +1, 0, -1. Where the recoding does contain a -1 digit, one shared stage forms -x up front, and every later stage is a plain adder of x or -x.

Each adder stage works only on a window of the partial sum about `M` bits wide. Bits below the current digit position are already final, so they bypass the rest of the chain and go straight to the product. When the window shifts up, the vacated upper inputs are filled with ones if the partial sum is negative and with zeros otherwise.

A single register with a clock enable holds the product.

Top module: `cmul_const`

## Requirements
- R1: On a rising clock edge with `en` high, `p` takes the value `x*K`. This product is exact in `M+N` bits and appears one cycle after `x` was applied.
- R2: While `rst_n` is low, `p` reads zero. This takes effect at once, without waiting for a clock edge.
- R3: On a rising edge with `en` low, `p` keeps its previous value whatever `x` does.
- R4: With `K = 0`, `p` is zero for every value of `x`.
- R5: With `K` a power of two `2^s`, `p` is `x` shifted left by `s` for every `x`.
- R6: With `K = 3` (a pair of ones at the top of the constant), `p` is `3x` for every `x`.
- R7: With `K = 221`, `p` is `221x` for every `x`. This constant recodes, most significant digit first, to +1 0 0 -1 0 0 -1 0 +1.
- R8: With `K` all ones (`2^N-1`), `p` is `x*(2^N-1)` for every `x`.
- R9: The partial sum entering a stage is negative exactly when the previous non-zero digit is -1 and `x` is non-zero. The -x stage output is negative exactly when `x` is non-zero.
- R10: The partial sum leaving the last stage is never negative.
- R11: With an operand width and constant width other than 8 by 8 (6-bit `x`, 10-bit `K = 1000`), `p` is `x*K` for every `x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the product register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the product |
| en | input | 1 | Clock enable of the product register |
| x | input | M | Unsigned operand |
| p | output | M+N | Registered unsigned product `x*K` |

## Verification
Six copies of the block, each built with a different constant, see the same sweep of every operand value with the enable held high:
- The zero and power-of-two copies separate the adder-free wiring paths from the adder chain.
- The constant 3 exercises the top-pair exception.
- 221 and the all-ones constant exercise long subtract chains, where the sign fill on negative partial sums matters.
- The 6-by-10 copy with constant 1000 catches width and offset mistakes in the bits that leave the chain early.

A second phase toggles the enable on every cycle while the operand keeps changing, which separates capture from hold. A reset asserted between clock edges checks that the clear takes effect at once.

// File: rtl/cm_pkg.sv
package cm_pkg;

  // Signed digit at position idx of the modified non-adjacent recoding of k.
  // A remaining value of exactly 3 is kept as two +1 digits.
  function automatic int digit_at(logic [63:0] k, int idx);
    logic [64:0] v;
    int d;
    v = {1'b0, k};
    d = 0;
    for (int i = 0; i <= idx; i++) begin
      if (!v[0]) begin
        d = 0;
        v = v >> 1;
      end else if (v == 65'd3 || !v[1]) begin
        d = 1;
        v = (v - 65'd1) >> 1;
      end else begin
        d = -1;
        v = (v + 65'd1) >> 1;
      end
    end
    return d;
  endfunction

  // Number of non-zero digits over positions 0..n.
  function automatic int count_nz(logic [63:0] k, int n);
    int c;
    c = 0;
    for (int i = 0; i <= n; i++)
      if (digit_at(k, i) != 0) c++;
    return c;
  endfunction

  // Position of the j-th non-zero digit, counting from the least significant.
  function automatic int pos_of(logic [63:0] k, int n, int j);
    int c;
    int p;
    c = 0;
    p = 0;
    for (int i = 0; i <= n; i++) begin
      if (digit_at(k, i) != 0) begin
        if (c == j) p = i;
        c++;
      end
    end
    return p;
  endfunction

  // Whether the j-th non-zero digit is -1.
  function automatic bit neg_of(logic [63:0] k, int n, int j);
    return digit_at(k, pos_of(k, n, j)) < 0;
  endfunction

  // Whether the recoding holds any -1 digit.
  function automatic bit has_neg(logic [63:0] k, int n);
    bit r;
    r = 1'b0;
    for (int i = 0; i <= n; i++)
      if (digit_at(k, i) < 0) r = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/cm_negate.sv
module cm_negate #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);

  // Shared -x term, built once for the whole chain.
  assign y = '0 - a;

  // R9: the negated operand is negative exactly when the operand is non-zero.
  a_r9_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    y[W-1] == (a != '0));

endmodule

// File: rtl/cm_stage.sv
module cm_stage #(
  parameter int W         = 10,
  parameter int SHIFT     = 1,
  parameter bit FILL_SIGN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     acc_in,
  input  logic [W-1:0]     term,
  output logic [W-1:0]     acc_out,
  output logic [SHIFT-1:0] low_out
);

  logic             fill;
  logic [W+SHIFT-1:0] wide;
  logic [W-1:0]     win;

  // Free upper inputs get ones only behind a digit known to leave the sum negative.
  assign fill    = FILL_SIGN ? acc_in[W-1] : 1'b0;
  assign wide    = {{SHIFT{fill}}, acc_in};
  assign low_out = wide[SHIFT-1:0];
  assign win     = wide[W+SHIFT-1:SHIFT];
  assign acc_out = win + term;

  // R9: incoming partial sum is negative only after a -1 digit with x non-zero.
  a_r9_partial_sign: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in[W-1] == (FILL_SIGN && (acc_in != '0)));

endmodule

// File: rtl/cm_outreg.sv
module cm_outreg #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (en) q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign q = q_r;
  end else begin : g_comb
    assign q = d;
  end

endmodule

// File: rtl/cmul_const.sv
module cmul_const #(
  parameter int          M       = 8,
  parameter int          N       = 8,
  parameter logic [63:0] K       = 64'd221,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [M-1:0] x,
  output logic [M+N-1:0] p
);

  localparam int          PW  = M + N;
  localparam int          SW  = M + 2;
  localparam logic [63:0] KM  = K & ((64'd1 << N) - 64'd1);
  localparam logic [PW-1:0] KP = KM[PW-1:0];
  localparam int          NZ  = cm_pkg::count_nz(KM, N);
  localparam bit          NEG = cm_pkg::has_neg(KM, N);
  localparam int          NZA = (NZ == 0) ? 1 : NZ;

  logic [SW-1:0] xe;
  logic [SW-1:0] xn;
  logic [SW-1:0] acc [NZA];
  logic [PW-1:0] low [NZA];
  logic [PW-1:0] prod_c;

  assign xe = {2'b00, x};

  if (NEG) begin : g_neg
    cm_negate #(.W(SW)) u_neg (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (xe),
      .y     (xn)
    );
  end else begin : g_noneg
    assign xn = '0;
  end

  if (NZ == 0) begin : g_zero
    assign acc[0] = '0;
    assign low[0] = '0;
    assign prod_c = '0;
  end else begin : g_chain
    for (genvar j = 0; j < NZ; j++) begin : g_dig
      localparam int PJ = cm_pkg::pos_of(KM, N, j);
      localparam bit DN = cm_pkg::neg_of(KM, N, j);
      if (j == 0) begin : g_first
        assign acc[0] = DN ? xn : xe;
        assign low[0] = '0;
      end else begin : g_add
        localparam int PP = cm_pkg::pos_of(KM, N, j - 1);
        localparam bit PN = cm_pkg::neg_of(KM, N, j - 1);
        localparam int SH = PJ - PP;
        logic [SH-1:0] lbits;
        cm_stage #(.W(SW), .SHIFT(SH), .FILL_SIGN(PN)) u_stage (
          .clk     (clk),
          .rst_n   (rst_n),
          .acc_in  (acc[j-1]),
          .term    (DN ? xn : xe),
          .acc_out (acc[j]),
          .low_out (lbits)
        );
        // Settled low bits of the previous window leave the chain here.
        assign low[j] = low[j-1] | (PW'(lbits) << PP);
      end
    end

    localparam int PL = cm_pkg::pos_of(KM, N, NZ - 1);
    assign prod_c = low[NZ-1] | (PW'(acc[NZ-1]) << PL);

    // R10: the last partial sum is never negative.
    a_r10_final_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      !acc[NZ-1][SW-1]);
  end

  cm_outreg #(.W(PW), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (prod_c),
    .q     (p)
  );

  if (REG_OUT) begin : g_chk
    logic [PW-1:0] xw;
    assign xw = PW'(x);

    // R1: an enabled edge loads the exact product of the operand seen there.
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (p == $past(xw) * KP));

    // R3: a disabled edge leaves the product untouched.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(p));
  end

endmodule

// File: tb/cmul_const_test.sv
`timescale 1ns/1ps
module cmul_const_test;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [7:0]  x8;
  logic [15:0] pv [6];
  longint      exp_q [6];
  int          errors;
  int          checks;
  bit          done;

  localparam longint KV [6] = '{0, 16, 3, 221, 255, 1000};
  localparam longint XM [6] = '{255, 255, 255, 255, 255, 63};

  initial clk = 1'b0;
  always #2 clk = ~clk;

  cmul_const #(.M(8), .N(8), .K(64'd0))    uut   (.clk(clk), .rst_n(rst_n), .en(en), .x(x8),      .p(pv[0]));
  cmul_const #(.M(8), .N(8), .K(64'd16))   u_p2  (.clk(clk), .rst_n(rst_n), .en(en), .x(x8),      .p(pv[1]));
  cmul_const #(.M(8), .N(8), .K(64'd3))    u_k3  (.clk(clk), .rst_n(rst_n), .en(en), .x(x8),      .p(pv[2]));
  cmul_const #(.M(8), .N(8), .K(64'd221))  u_k221(.clk(clk), .rst_n(rst_n), .en(en), .x(x8),      .p(pv[3]));
  cmul_const #(.M(8), .N(8), .K(64'd255))  u_ones(.clk(clk), .rst_n(rst_n), .en(en), .x(x8),      .p(pv[4]));
  cmul_const #(.M(6), .N(10), .K(64'd1000)) u_wide(.clk(clk), .rst_n(rst_n), .en(en), .x(x8[5:0]), .p(pv[5]));

  // Behavioural reference: a register loaded with operand times constant.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) exp_q[i] = 0;
    end else if (en) begin
      for (int i = 0; i < 6; i++) exp_q[i] = (longint'(x8) & XM[i]) * KV[i];
    end
  end

  function automatic string tag_of(int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check_all(string phase);
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (longint'(pv[i]) != exp_q[i]) begin
        errors++;
        $display("FAIL %s/%s K=%0d: got %0d expected %0d", tag_of(i), phase, KV[i], pv[i], exp_q[i]);
      end
    end
  endtask

  initial begin
    errors = 0;
    checks = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    en     = 1'b0;
    x8     = 8'd0;
    repeat (3) @(negedge clk);
    check_all("R2 reset");
    rst_n = 1'b1;

    // Full operand sweep with enable high (R1 and the per-constant checks).
    en = 1'b1;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      check_all("R1 sweep");
      x8 = 8'(i);
    end

    // Enable toggling with a moving operand (R3 hold versus R1 capture).
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      check_all("R3 hold");
      en = i[0];
      x8 = 8'(i * 37 + 5);
    end

    // Reset between edges must clear at once (R2).
    en = 1'b1;
    x8 = 8'd200;
    @(negedge clk);
    check_all("R1 pre-reset");
    #1 rst_n = 1'b0;
    #0.5 check_all("R2 async");
    @(negedge clk);
    check_all("R2 held");
    rst_n = 1'b1;
    x8 = 8'd255;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_all("R1 after reset");
      x8 = 8'(x8 - 8'd17);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule